// File: doc/BRIEF.md
# CPU Clock Domain Control Register Block

This block holds the clock settings of a processor clock domain as a small set of memory-mapped registers, and shows how those settings settle over time. One register picks the parent of the core clock: the main PLL or an alternate clock. The same register also picks the source of the performance-monitor clock. Two divider registers hold 3-bit ratio fields. A field value v divides by v+1. The fields are the core ratio, the trace/debug bus ratio, the copy-clock ratio and the performance-monitor ratio.

The block generates no clocks. Each write makes a settle counter show a transition: the parent mux reports an "in transition" code, and each divider field that was written raises its own busy bit. Software or a hardware sequencer programs a setting, then polls the status registers until the transition has finished before it takes the next step. For example, it moves the core clock to the alternate parent, waits for the mux, rewrites the dividers, and waits for them too. Accesses are single-cycle word writes with byte-lane strobes. Reads are combinational on the same address bus. The settle windows are the parameters MUX_SETTLE and DIV_SETTLE.

Top module: `cpuclk_regs`

## Requirements
- R1: After reset, register 0x000 reads 0, register 0x200 reads 0x0001_0000, registers 0x300, 0x304, 0x400 and 0x404 read 0.
- R2: Register 0x000 stores bit 16 (core parent: 0 = main PLL, 1 = alternate clock) and bit 20 (performance-monitor clock from the main path). Both bits are written through byte lane 2 (strobe bit 2). All other bits read 0.
- R3: Bits [18:16] of register 0x200 read 1 when the main PLL is the settled parent and 2 when the alternate clock is the settled parent. After any write to lane 2 of 0x000, even one with an unchanged value, they read 4 for MUX_SETTLE cycles, then show the new parent. All other bits read 0.
- R4: Register 0x300 holds the core ratio in bits [2:0] (lane 0) and the trace/debug ratio in bits [18:16] (lane 2). All other bits read 0.
- R5: Register 0x304 holds the copy-clock ratio in bits [2:0] and the performance-monitor ratio in bits [6:4], both in lane 0. All other bits read 0.
- R6: Divider status bit 0 and bit 16 of 0x400 belong to the core and trace fields. Bit 0 and bit 4 of 0x404 belong to the copy and performance-monitor fields. Each bit reads 1 for DIV_SETTLE cycles after its field is written, even with its current value, and reads 0 otherwise. All other status bits read 0.
- R7: A field is updated, and starts a settle window, only if the strobe of its byte lane is set in that write.
- R8: A write to a field that is still settling restarts the full settle window from that write.
- R9: Any address other than the six listed, including unaligned ones, reads 0 and ignores writes. Writes to 0x200, 0x400 and 0x404 change no state and start no settle window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | ADDR_W | Byte address for reads and writes |
| bus_wdata | input | DATA_W | Write data |
| bus_strb | input | DATA_W/8 | Byte-lane enables for writes |
| bus_rdata | output | DATA_W | Read data for bus_addr (combinational) |

## Verification
A vector table writes all-ones words, partial-strobe words and words with single fields to each configuration register, then reads the register back. This shows whether the storage masks and the lane routing are correct, and whether a disabled lane leaves its field alone. Directed sequences poll the status registers at the first and last cycle of each window and at the cycle just after it. They cover a parent change, a same-value rewrite and a rewrite during a window, which separates a correct window length from one that is off by one, ignores rewrites, or fails to restart. Writes to unmapped addresses, unaligned addresses and status registers are then followed by reads of every register, to show that nothing moved and no busy bit rose.

// File: rtl/cpuclk_pkg.sv
package cpuclk_pkg;
    localparam int unsigned OFS_SRC = 32'h000;
    localparam int unsigned OFS_MST = 32'h200;
    localparam int unsigned OFS_DC0 = 32'h300;
    localparam int unsigned OFS_DC1 = 32'h304;
    localparam int unsigned OFS_DS0 = 32'h400;
    localparam int unsigned OFS_DS1 = 32'h404;

    localparam int unsigned RATIO_W     = 3;
    localparam int unsigned MST_W       = 3;
    localparam int unsigned B_CORE_SEL  = 16;
    localparam int unsigned B_PM_SEL    = 20;
    localparam int unsigned B_MST       = 16;
    localparam int unsigned B_DIV_CORE  = 0;
    localparam int unsigned B_DIV_TRACE = 16;
    localparam int unsigned B_DIV_COPY  = 0;
    localparam int unsigned B_DIV_PM    = 4;

    localparam int unsigned NDIV      = 4;
    localparam int unsigned IDX_CORE  = 0;
    localparam int unsigned IDX_TRACE = 1;
    localparam int unsigned IDX_COPY  = 2;
    localparam int unsigned IDX_PM    = 3;

    localparam logic [MST_W-1:0] MST_MAIN   = 3'd1;
    localparam logic [MST_W-1:0] MST_ALT    = 3'd2;
    localparam logic [MST_W-1:0] MST_MOVING = 3'd4;

    typedef struct packed {
        logic               core_alt;
        logic               pm_main;
        logic [RATIO_W-1:0] div_core;
        logic [RATIO_W-1:0] div_trace;
        logic [RATIO_W-1:0] div_copy;
        logic [RATIO_W-1:0] div_pm;
    } ctl_t;

    typedef struct packed {
        logic src;
        logic mst;
        logic dc0;
        logic dc1;
        logic ds0;
        logic ds1;
    } sel_t;
endpackage

// File: rtl/cpuclk_settle.sv
module cpuclk_settle #(
    parameter int unsigned CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int unsigned CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = CNT_W'(CYCLES);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign busy = (cnt_q != '0);

    // R6: a write always opens a window on the next cycle
    p_busy_after_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

    // R8: busy only ever rises because of a write
    p_busy_rise_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
endmodule

// File: rtl/cpuclk_decode.sv
module cpuclk_decode
    import cpuclk_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output sel_t              sel,
    output logic              hit
);
    always_comb begin
        sel     = '0;
        sel.src = (addr == ADDR_W'(OFS_SRC));
        sel.mst = (addr == ADDR_W'(OFS_MST));
        sel.dc0 = (addr == ADDR_W'(OFS_DC0));
        sel.dc1 = (addr == ADDR_W'(OFS_DC1));
        sel.ds0 = (addr == ADDR_W'(OFS_DS0));
        sel.ds1 = (addr == ADDR_W'(OFS_DS1));
        hit     = |sel;
    end
endmodule

// File: rtl/cpuclk_regs.sv
module cpuclk_regs
    import cpuclk_pkg::*;
#(
    parameter int unsigned ADDR_W     = 12,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned MUX_SETTLE = 4,
    parameter int unsigned DIV_SETTLE = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic [DATA_W/8-1:0] bus_strb,
    output logic [DATA_W-1:0]   bus_rdata
);
    localparam int unsigned LANE_W = 8;

    sel_t            sel;
    logic            map_hit;
    ctl_t            ctl_d, ctl_q;
    logic            we_src;
    logic [NDIV-1:0] div_start;
    logic [NDIV-1:0] div_busy;
    logic            mux_busy;
    logic            unused_bits;

    assign unused_bits = ^{bus_wdata, bus_strb};

    cpuclk_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (bus_addr),
        .sel  (sel),
        .hit  (map_hit)
    );

    always_comb begin
        we_src               = bus_wr && sel.src && bus_strb[B_CORE_SEL / LANE_W];
        div_start[IDX_CORE]  = bus_wr && sel.dc0 && bus_strb[B_DIV_CORE / LANE_W];
        div_start[IDX_TRACE] = bus_wr && sel.dc0 && bus_strb[B_DIV_TRACE / LANE_W];
        div_start[IDX_COPY]  = bus_wr && sel.dc1 && bus_strb[B_DIV_COPY / LANE_W];
        div_start[IDX_PM]    = bus_wr && sel.dc1 && bus_strb[B_DIV_PM / LANE_W];
    end

    always_comb begin
        ctl_d = ctl_q;
        if (we_src) begin
            ctl_d.core_alt = bus_wdata[B_CORE_SEL];
            ctl_d.pm_main  = bus_wdata[B_PM_SEL];
        end
        if (div_start[IDX_CORE])  ctl_d.div_core  = bus_wdata[B_DIV_CORE +: RATIO_W];
        if (div_start[IDX_TRACE]) ctl_d.div_trace = bus_wdata[B_DIV_TRACE +: RATIO_W];
        if (div_start[IDX_COPY])  ctl_d.div_copy  = bus_wdata[B_DIV_COPY +: RATIO_W];
        if (div_start[IDX_PM])    ctl_d.div_pm    = bus_wdata[B_DIV_PM +: RATIO_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    cpuclk_settle #(.CYCLES(MUX_SETTLE)) u_mux_settle (
        .clk   (clk),
        .rst_n (rst_n),
        .start (we_src),
        .busy  (mux_busy)
    );

    for (genvar g = 0; g < NDIV; g++) begin : g_div
        cpuclk_settle #(.CYCLES(DIV_SETTLE)) u_div_settle (
            .clk   (clk),
            .rst_n (rst_n),
            .start (div_start[g]),
            .busy  (div_busy[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (sel.src) begin
            bus_rdata[B_CORE_SEL] = ctl_q.core_alt;
            bus_rdata[B_PM_SEL]   = ctl_q.pm_main;
        end
        if (sel.mst) begin
            bus_rdata[B_MST +: MST_W] = mux_busy       ? MST_MOVING :
                                        ctl_q.core_alt ? MST_ALT : MST_MAIN;
        end
        if (sel.dc0) begin
            bus_rdata[B_DIV_CORE +: RATIO_W]  = ctl_q.div_core;
            bus_rdata[B_DIV_TRACE +: RATIO_W] = ctl_q.div_trace;
        end
        if (sel.dc1) begin
            bus_rdata[B_DIV_COPY +: RATIO_W] = ctl_q.div_copy;
            bus_rdata[B_DIV_PM +: RATIO_W]   = ctl_q.div_pm;
        end
        if (sel.ds0) begin
            bus_rdata[B_DIV_CORE]  = div_busy[IDX_CORE];
            bus_rdata[B_DIV_TRACE] = div_busy[IDX_TRACE];
        end
        if (sel.ds1) begin
            bus_rdata[B_DIV_COPY] = div_busy[IDX_COPY];
            bus_rdata[B_DIV_PM]   = div_busy[IDX_PM];
        end
    end

    // R3: a parent write is followed by a transition window
    p_mux_moving_after_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        we_src |=> mux_busy);

    // R9: writes outside the map leave every setting untouched
    p_unmapped_no_effect_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !map_hit) |=> (ctl_q == $past(ctl_q)));

    // R7: a core ratio write without lane 0 keeps the field
    p_lane_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel.dc0 && !bus_strb[B_DIV_CORE / LANE_W]) |=> $stable(ctl_q.div_core));

    // R2: the parent bit changes only through a lane-2 write to the select register
    p_src_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && sel.src) |=> $stable(ctl_q.core_alt));
endmodule

// File: tb/cpuclk_regs_bench.sv
module cpuclk_regs_bench;
    localparam int unsigned MS = 5;
    localparam int unsigned DS = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_strb = '0;
    logic [31:0] bus_rdata;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    cpuclk_regs #(.ADDR_W(12), .DATA_W(32), .MUX_SETTLE(MS), .DIV_SETTLE(DS)) u_cpuclk_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_strb  (bus_strb),
        .bus_rdata (bus_rdata)
    );

    always #10 clk = ~clk;

    localparam int NV = 10;
    localparam logic [11:0] VA [NV] = '{12'h000, 12'h000, 12'h000, 12'h300, 12'h300,
                                        12'h300, 12'h304, 12'h304, 12'h304, 12'h000};
    localparam logic [31:0] VD [NV] = '{32'h0011_0000, 32'hFFFF_FFFF, 32'h0000_0000,
                                        32'hFFFF_FFFF, 32'h0000_0002, 32'h0005_0000,
                                        32'hFFFF_FFFF, 32'h0000_0035, 32'h0000_0035,
                                        32'h0000_0000};
    localparam logic [3:0]  VS [NV] = '{4'hF, 4'hF, 4'b1011, 4'hF, 4'b0001,
                                        4'b0100, 4'hF, 4'b1110, 4'b0001, 4'b0100};
    localparam logic [31:0] VE [NV] = '{32'h0011_0000, 32'h0011_0000, 32'h0011_0000,
                                        32'h0007_0007, 32'h0007_0002, 32'h0005_0002,
                                        32'h0000_0077, 32'h0000_0077, 32'h0000_0035,
                                        32'h0000_0000};

    function automatic string vtag(input int i);
        case (i)
            0, 1, 9: vtag = "R2";
            2:       vtag = "R7 (select lane 2 off)";
            3, 4, 5: vtag = "R4";
            7:       vtag = "R7 (divider lane 0 off)";
            default: vtag = "R5";
        endcase
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] s);
        bus_addr  = a;
        bus_wdata = d;
        bus_strb  = s;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rchk(input logic [11:0] a, input logic [31:0] e, input string tag);
        bus_addr = a;
        #1;
        total++;
        if (bus_rdata !== e) begin
            fails++;
            $display("FAIL %s addr %h actual %h expected %h", tag, a, bus_rdata, e);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1 reset state
        rchk(12'h000, 32'h0, "R1");
        rchk(12'h200, 32'h0001_0000, "R1");
        rchk(12'h300, 32'h0, "R1");
        rchk(12'h304, 32'h0, "R1");
        rchk(12'h400, 32'h0, "R1");
        rchk(12'h404, 32'h0, "R1");

        // table walk: write, let everything settle, read back
        for (int i = 0; i < NV; i++) begin
            wr(VA[i], VD[i], VS[i]);
            tick(MS + 1);
            rchk(VA[i], VE[i], vtag(i));
        end

        // R3 parent change to the alternate clock
        wr(12'h000, 32'h0001_0000, 4'b0100);
        rchk(12'h000, 32'h0001_0000, "R2");
        rchk(12'h200, 32'h0004_0000, "R3 first moving cycle");
        tick(MS - 1);
        rchk(12'h200, 32'h0004_0000, "R3 last moving cycle");
        tick(1);
        rchk(12'h200, 32'h0002_0000, "R3 alternate settled");
        // R3 same-value rewrite still moves
        wr(12'h000, 32'h0001_0000, 4'b0100);
        rchk(12'h200, 32'h0004_0000, "R3 same value");
        tick(MS);
        rchk(12'h200, 32'h0002_0000, "R3 same value settled");
        // R8 rewrite during the window restarts it
        wr(12'h000, 32'h0000_0000, 4'b0100);
        tick(3);
        wr(12'h000, 32'h0000_0000, 4'b0100);
        tick(MS - 1);
        rchk(12'h200, 32'h0004_0000, "R8 mux restart");
        tick(1);
        rchk(12'h200, 32'h0001_0000, "R8 main settled");

        // R6 core field busy only
        wr(12'h300, 32'h0000_0004, 4'b0001);
        rchk(12'h400, 32'h0000_0001, "R6 core busy");
        rchk(12'h300, 32'h0005_0004, "R4");
        tick(DS - 1);
        rchk(12'h400, 32'h0000_0001, "R6 core last busy");
        tick(1);
        rchk(12'h400, 32'h0, "R6 core clear");
        // R6 trace field through lane 2, then the same value again
        wr(12'h300, 32'h0003_0000, 4'b0100);
        rchk(12'h400, 32'h0001_0000, "R6 trace busy");
        tick(DS);
        rchk(12'h400, 32'h0, "R6 trace clear");
        wr(12'h300, 32'h0003_0000, 4'b0100);
        rchk(12'h400, 32'h0001_0000, "R6 same value busy");
        tick(DS);
        // R6 second divider register bit positions
        wr(12'h304, 32'h0000_0035, 4'b0001);
        rchk(12'h404, 32'h0000_0011, "R6 div1 busy");
        tick(DS);
        rchk(12'h404, 32'h0, "R6 div1 clear");
        // R8 divider restart
        wr(12'h304, 32'h0000_0035, 4'b0001);
        tick(2);
        wr(12'h304, 32'h0000_0035, 4'b0001);
        tick(DS - 1);
        rchk(12'h404, 32'h0000_0011, "R8 div restart");
        tick(1);
        rchk(12'h404, 32'h0, "R8 div clear");

        // R9 unmapped, unaligned and read-only targets
        wr(12'h308, 32'hFFFF_FFFF, 4'hF);
        rchk(12'h308, 32'h0, "R9 unmapped read");
        rchk(12'h404, 32'h0, "R9 no busy");
        wr(12'h400, 32'hFFFF_FFFF, 4'hF);
        rchk(12'h400, 32'h0, "R9 status write");
        rchk(12'h300, 32'h0003_0004, "R9 div0 kept");
        wr(12'h302, 32'hFFFF_FFFF, 4'hF);
        rchk(12'h302, 32'h0, "R9 unaligned read");
        rchk(12'h300, 32'h0003_0004, "R9 unaligned write");
        rchk(12'h304, 32'h0000_0035, "R9 div1 kept");
        wr(12'h200, 32'hFFFF_FFFF, 4'hF);
        rchk(12'h200, 32'h0001_0000, "R9 mux status write");
        rchk(12'h000, 32'h0, "R9 select kept");
        rchk(12'h204, 32'h0, "R9 unmapped 0x204");

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule